// File: doc/BRIEF.md
# Flow-Gated Serial Transmitter

This block turns bytes that a host writes into asynchronous serial characters on a single transmit line. Bytes land in a 32-entry queue. The serializer takes them out one at a time and frames each one with a start bit, 5 to 8 data bits, an optional parity bit and a stop field of 1, 1.5 or 2 bit periods. The block does not keep time itself. It advances on a tick strobe from an external baud generator, and a configuration field sets each bit period to 16, 8 or 4 ticks.

With hardware flow control switched on, the clear-to-send input (active low) decides whether a new character may begin. A character that has already started always runs to its end. The host can read how many bytes are queued, whether the queue is empty, and whether a write was ever lost to a full queue.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset the line `tx` is 1, `fifo_level` is 0, `fifo_empty` is 1 and `overflow` is 0.
- R2: Each character starts with one bit at 0, followed by the data bits least significant first. The line rests at 1 between characters.
- R3: `cfg_data_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Byte bits above the selected length are not sent.
- R4: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd` at 0 the parity makes the count of ones over data and parity even. With `cfg_parity_odd` at 1 that count is odd.
- R5: `cfg_osr` sets N, the number of ticks in one bit period: 0 gives 16, 1 gives 8, 2 gives 4 and 3 gives 16. `tx` changes only on a clock edge where `tick` is 1.
- R6: `cfg_stop` sets the stop field, which is at 1: 0 gives N ticks, 1 gives 3N/2 ticks, and 2 or 3 gives 2N ticks. Characters sent back to back start exactly N*(1+D+P)+S ticks apart, where D is the data length, P is the parity bit count and S is the stop length.
- R7: The queue holds 32 bytes. `fifo_level` gives the number of queued bytes and `fifo_empty` is 1 exactly when that number is 0. A byte leaves the queue when its character starts.
- R8: A write while the queue holds 32 bytes is dropped, and the level stays at 32. It sets `overflow`, which then stays at 1 until reset.
- R9: With `cfg_afc_en` at 1, no character starts while `cts_n` is 1, and queued bytes stay queued. Characters start once `cts_n` is 0.
- R10: If `cts_n` goes to 1 while a character is on the line, that character still finishes in full.
- R11: With `cfg_afc_en` at 0, `cts_n` has no effect and queued bytes are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe that puts one byte into the queue |
| wr_data | input | 8 | Byte to queue |
| cfg_data_len | input | 2 | Data length select |
| cfg_parity_en | input | 1 | Parity bit enable |
| cfg_parity_odd | input | 1 | Odd parity select |
| cfg_stop | input | 2 | Stop length select |
| cfg_osr | input | 2 | Ticks-per-bit select |
| cfg_afc_en | input | 1 | Automatic clear-to-send gating enable |
| tick | input | 1 | Oversampling tick strobe |
| cts_n | input | 1 | Clear to send, active low |
| tx | output | 1 | Serial output |
| fifo_level | output | 6 | Count of queued bytes |
| fifo_empty | output | 1 | Queue empty flag |
| overflow | output | 1 | Sticky lost-write flag |

## Verification
The bench measures the spacing, in ticks, between back-to-back start edges for several combinations of tick factor, data length, parity and stop length. The 1.5-stop case at a factor of 4 matters most here, because a stop counter that ignored the factor, or rounded the half bit, would shift that spacing by at least one tick. Short characters are sent with their upper byte bits set. A serializer that did not mask those bits, or that computed parity over all eight bits, would give the wrong data or parity bit. Clear-to-send is taken away in the middle of a character. A design that cut the character short would fail the frame check, and one that checked the line only once would let the next character start. The queue is then driven past full. A design that accepted the extra writes, or that cleared the overflow flag, would give a wrong count of sent characters or a wrong flag value.

// File: rtl/uart_cts_tx_pkg.sv
`timescale 1ns/1ps
package uart_cts_tx_pkg;

  localparam int OSR_MAX = 16;
  localparam int CNT_W   = $clog2(2 * OSR_MAX) + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } ser_state_t;

  // ticks in one bit period for a given oversampling select
  function automatic logic [CNT_W-1:0] ticks_per_bit(input logic [1:0] sel);
    case (sel)
      2'd1:    return CNT_W'(OSR_MAX / 2);
      2'd2:    return CNT_W'(OSR_MAX / 4);
      default: return CNT_W'(OSR_MAX);
    endcase
  endfunction

  // ticks in the stop field; the half-bit case follows the bit period
  function automatic logic [CNT_W-1:0] stop_len(input logic [1:0] osr_sel,
                                                input logic [1:0] stop_sel);
    logic [CNT_W-1:0] n;
    n = ticks_per_bit(osr_sel);
    case (stop_sel)
      2'd0:    return n;
      2'd1:    return n + (n >> 1);
      default: return n << 1;
    endcase
  endfunction

endpackage

// File: rtl/uart_cts_tx_fifo.sv
`timescale 1ns/1ps
module uart_cts_tx_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              overflow
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = pop && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
    if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
      if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
      if (wr_en && full) overflow <= 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assert_level_max_R7: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !pop) |=> (level == LVL_W'(DEPTH)) && overflow);

endmodule

// File: rtl/uart_cts_tx_ser.sv
`timescale 1ns/1ps
module uart_cts_tx_ser
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        cfg_data_len,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_osr,
  input  logic              cfg_afc_en,
  input  logic              cts_n,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] rd_data,
  output logic              pop,
  output logic              tx
);

  ser_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  bit_last, stop_last;
  logic [IDX_W-1:0]  bit_idx, idx_last;
  logic [DATA_W-1:0] shreg, mask;
  logic              par_bit, load_pend, can_start, bit_end, stop_end;

  assign bit_last  = ticks_per_bit(cfg_osr) - CNT_W'(1);
  assign stop_last = stop_len(cfg_osr, cfg_stop) - CNT_W'(1);
  assign idx_last  = IDX_W'(DATA_W - 4) + IDX_W'(cfg_data_len);
  assign bit_end   = (cnt == bit_last);
  assign stop_end  = (cnt == stop_last);
  assign can_start = !fifo_empty && (!cfg_afc_en || !cts_n);
  assign pop       = tick && can_start &&
                     ((state == S_IDLE) || ((state == S_STOP) && stop_end));

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      mask[i] = (i <= int'(idx_last));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tx        <= 1'b1;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      if (load_pend) begin
        shreg   <= rd_data & mask;
        par_bit <= (^(rd_data & mask)) ^ cfg_parity_odd;
      end
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (can_start) begin
              state     <= S_START;
              tx        <= 1'b0;
              cnt       <= '0;
              load_pend <= 1'b1;
            end
          end
          S_START: begin
            if (bit_end) begin
              state   <= S_DATA;
              tx      <= shreg[0];
              cnt     <= '0;
              bit_idx <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          S_DATA: begin
            if (bit_end) begin
              cnt <= '0;
              if (bit_idx == idx_last) begin
                state <= cfg_parity_en ? S_PAR : S_STOP;
                tx    <= cfg_parity_en ? par_bit : 1'b1;
              end else begin
                bit_idx <= bit_idx + IDX_W'(1);
                shreg   <= shreg >> 1;
                tx      <= shreg[1];
              end
            end else cnt <= cnt + CNT_W'(1);
          end
          S_PAR: begin
            if (bit_end) begin
              state <= S_STOP;
              tx    <= 1'b1;
              cnt   <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          S_STOP: begin
            if (stop_end) begin
              cnt <= '0;
              if (can_start) begin
                state     <= S_START;
                tx        <= 1'b0;
                load_pend <= 1'b1;
              end else state <= S_IDLE;
            end else cnt <= cnt + CNT_W'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_tick_only_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tx));

  assert_cts_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && cfg_afc_en && cts_n) |=> (state == S_IDLE));

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !fifo_empty);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_START) |-> !tx);

  assert_stop_high_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP || state == S_IDLE) |-> tx);

endmodule

// File: rtl/uart_cts_tx.sv
`timescale 1ns/1ps
module uart_cts_tx #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_data_len,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_osr,
  input  logic              cfg_afc_en,
  input  logic              tick,
  input  logic              cts_n,
  output logic              tx,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_empty,
  output logic              overflow
);

  logic              pop;
  logic [DATA_W-1:0] rd_data;

  uart_cts_tx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pop      (pop),
    .rd_data  (rd_data),
    .level    (fifo_level),
    .empty    (fifo_empty),
    .overflow (overflow)
  );

  uart_cts_tx_ser #(.DATA_W(DATA_W)) u_ser (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick),
    .cfg_data_len   (cfg_data_len),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_stop       (cfg_stop),
    .cfg_osr        (cfg_osr),
    .cfg_afc_en     (cfg_afc_en),
    .cts_n          (cts_n),
    .fifo_empty     (fifo_empty),
    .rd_data        (rd_data),
    .pop            (pop),
    .tx             (tx)
  );

endmodule

// File: tb/uart_cts_tx_tb.sv
`timescale 1ns/1ps
module uart_cts_tx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_data_len = 2'd3;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic [1:0] cfg_osr = 2'd0;
  logic       cfg_afc_en = 1'b0;
  logic       tick = 1'b0;
  logic       cts_n = 1'b0;
  logic       tx;
  logic [5:0] fifo_level;
  logic       fifo_empty;
  logic       overflow;

  uart_cts_tx u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_data_len(cfg_data_len), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_stop(cfg_stop), .cfg_osr(cfg_osr),
    .cfg_afc_en(cfg_afc_en), .tick(tick), .cts_n(cts_n), .tx(tx),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side view of the configuration
  int cN = 16, cD = 8, cP = 0, cOdd = 0, cS = 16;

  logic [7:0] exp_q[$];
  int         edges[$];
  int         frames = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // tick strobe on every other cycle, driven away from the active edge
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 2 == 0);
  end

  // monitor: samples each bit at mid-period counted in ticks
  int   tcnt = 0, t0 = 0, k = 0, nbits = 0;
  bit   busy = 0;
  logic prev_tx = 1'b1;
  logic tk;
  logic [15:0] bits;

  task automatic check_frame();
    logic [7:0] got, e;
    logic       pexp;
    got = '0;
    for (int i = 0; i < cD; i++) got[i] = bits[1+i];
    chk(bits[0] == 1'b0, "R2", "start bit", int'(bits[0]), 0);
    chk(bits[nbits-1] == 1'b1, "R6", "stop bit", int'(bits[nbits-1]), 1);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2", "unexpected character", int'(got), -1);
    end else begin
      e = exp_q.pop_front();
      chk(got == e, "R3", "data field", int'(got), int'(e));
      if (cP != 0) begin
        pexp = (^e) ^ cOdd[0];
        chk(bits[1+cD] == pexp, "R4", "parity bit", int'(bits[1+cD]), int'(pexp));
      end
    end
    frames++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      tk = tick;
      #1;
      if (rst) begin
        prev_tx = 1'b1;
        busy = 0;
      end else begin
        if (tk) tcnt++;
        if (tx !== prev_tx && !tk)
          chk(1'b0, "R5", "tx moved without tick", int'(tx), int'(prev_tx));
        if (!busy && prev_tx == 1'b1 && tx == 1'b0) begin
          busy = 1; t0 = tcnt; k = 0; nbits = 2 + cD + cP;
          edges.push_back(tcnt);
        end else if (busy && tk && (tcnt - t0) == k * cN + cN / 2) begin
          bits[k] = tx;
          k++;
          if (k == nbits) begin
            busy = 0;
            check_frame();
          end
        end
        prev_tx = tx;
      end
    end
  end

  task automatic set_cfg(input int d, input int p, input int odd,
                         input int s, input int osr);
    @(negedge clk);
    cfg_data_len   = 2'(d - 5);
    cfg_parity_en  = p[0];
    cfg_parity_odd = odd[0];
    cfg_stop       = 2'(s);
    cfg_osr        = 2'(osr);
    cD = d; cP = p; cOdd = odd;
    cN = (osr == 1) ? 8 : (osr == 2) ? 4 : 16;
    cS = (s == 0) ? cN : (s == 1) ? cN + cN / 2 : 2 * cN;
  endtask

  task automatic write_byte(input logic [7:0] b, input bit keep);
    logic [7:0] m;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    m = 8'hFF >> (8 - cD);
    if (keep) exp_q.push_back(b & m);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_drain();
    int w = 0;
    while ((exp_q.size() != 0 || busy) && w < 60000) begin
      @(negedge clk);
      w++;
    end
    repeat (4 * cS + 8) @(negedge clk);
  endtask

  task automatic gap_run(input int d, input int p, input int odd,
                         input int s, input int osr, input logic [7:0] b0);
    int per;
    set_cfg(d, p, odd, s, osr);
    edges.delete();
    write_byte(b0, 1);
    write_byte(~b0, 1);
    write_byte(b0 ^ 8'h5A, 1);
    wait_drain();
    per = cN * (1 + cD + cP) + cS;
    chk(edges.size() == 3, "R6", "character count", edges.size(), 3);
    if (edges.size() == 3) begin
      chk(edges[1] - edges[0] == per, "R6", "back-to-back spacing 1", edges[1] - edges[0], per);
      chk(edges[2] - edges[1] == per, "R6", "back-to-back spacing 2", edges[2] - edges[1], per);
    end
    chk(fifo_empty == 1'b1 && fifo_level == 0, "R7", "queue drained", int'(fifo_level), 0);
  endtask

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    chk(tx == 1'b1, "R1", "tx in reset", int'(tx), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(tx == 1'b1, "R1", "tx idle", int'(tx), 1);
    chk(fifo_level == 0, "R1", "level after reset", int'(fifo_level), 0);
    chk(fifo_empty == 1'b1, "R1", "empty after reset", int'(fifo_empty), 1);
    chk(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);

    // R2 R5 R6: 8 data, no parity, 1 stop, 16 ticks
    gap_run(8, 0, 0, 0, 0, 8'hA5);
    // R4 even parity, 1.5 stop, 8 ticks, 7 bits with top bit set (R3)
    gap_run(7, 1, 0, 1, 1, 8'hC3);
    // R4 odd parity, 2 stop, 4 ticks, 5 bits (R3)
    gap_run(5, 1, 1, 2, 2, 8'hF6);
    // R6 1.5 stop at 4 ticks, 6 bits, select 3 gives 16 ticks (R5)
    gap_run(6, 0, 0, 1, 2, 8'h9D);
    gap_run(8, 1, 1, 3, 3, 8'h01);

    // R9: flow control holds queued bytes
    set_cfg(8, 0, 0, 0, 2);
    cfg_afc_en = 1'b1;
    cts_n = 1'b1;
    edges.delete();
    f0 = frames;
    write_byte(8'h11, 1);
    write_byte(8'h22, 1);
    write_byte(8'h33, 1);
    repeat (300) @(negedge clk);
    chk(edges.size() == 0, "R9", "no start while blocked", edges.size(), 0);
    chk(fifo_level == 3, "R9", "level while blocked", int'(fifo_level), 3);
    chk(fifo_empty == 1'b0, "R7", "not empty", int'(fifo_empty), 0);
    // R10: release, then block again mid-character
    cts_n = 1'b0;
    while (edges.size() == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    cts_n = 1'b1;
    repeat (400) @(negedge clk);
    chk(frames - f0 == 1, "R10", "single character completed", frames - f0, 1);
    chk(edges.size() == 1, "R10", "no second start", edges.size(), 1);
    chk(fifo_level == 2, "R9", "level after one sent", int'(fifo_level), 2);
    // R11: gating off, cts_n still high
    cfg_afc_en = 1'b0;
    wait_drain();
    chk(frames - f0 == 3, "R11", "characters sent with gating off", frames - f0, 3);
    chk(fifo_empty == 1'b1, "R11", "queue empty", int'(fifo_empty), 1);

    // R8: overflow
    cfg_afc_en = 1'b1;
    cts_n = 1'b1;
    f0 = frames;
    for (int i = 0; i < 34; i++) write_byte(8'(i * 7 + 3), i < 32);
    repeat (4) @(negedge clk);
    chk(fifo_level == 32, "R8", "level at full", int'(fifo_level), 32);
    chk(overflow == 1'b1, "R8", "overflow set", int'(overflow), 1);
    cts_n = 1'b0;
    wait_drain();
    chk(frames - f0 == 32, "R8", "only accepted bytes sent", frames - f0, 32);
    chk(exp_q.size() == 0, "R7", "scoreboard empty", exp_q.size(), 0);
    chk(overflow == 1'b1, "R8", "overflow sticky", int'(overflow), 1);
    chk(fifo_empty == 1'b1, "R7", "drained", int'(fifo_empty), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before all requirement checks ended: actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule